// File: doc/BRIEF.md
# Decade-Stretching Averaging Sample Scheduler

This block sits behind an ADC that delivers one signed 16-bit sample per strobe at a fixed base rate (at most one per microsecond). It turns that raw stream into a much shorter stream of averaged results. Each result is the mean of a window of consecutive raw samples. It carries a time tag, counted in raw-sample periods, that marks the middle of its window. Software arms a trace with a start pulse and the configuration inputs. The block then runs until it has emitted a set number of results or has consumed a set number of raw samples, and it signals the end with a one-cycle done pulse.

Two spacing schemes are offered. In logarithmic mode the first group of results uses single-sample windows. After every group of `cfgPerDecade` results the window becomes ten times longer, up to a parameterised ceiling of 10^MAX_EXP samples. Each group therefore covers about ten times the time span of the one before, and later results average more samples and carry less noise. Typical group sizes are 200, 1000 or 10000. In uniform mode every window has the fixed length `cfgUniWin`.

The averages come from a serial divider. A window that closes hands its sum to the divider, and accumulation of the next window starts at once. The divider's latency therefore sets the minimum spacing between raw strobes.

Top module: `lds_top`

## Requirements
- R1: After reset, and before any start pulse, `resValid` and `traceDone` stay 0, and raw strobes produce no result.
- R2: In logarithmic mode (`cfgLog`=1) the window length starts at 1 and is multiplied by 10 after every `cfgPerDecade` results, never exceeding 10^MAX_EXP. From that point every window has the ceiling length.
- R3: In uniform mode (`cfgLog`=0) every window is `cfgUniWin` raw samples long (`cfgUniWin` ≥ 1).
- R4: `resData` is the signed sum of the window's samples divided by the window length, truncated toward zero, as a 16-bit two's-complement value. Full-scale negative and positive inputs are reproduced exactly.
- R5: Raw samples are numbered from 0, starting with the first strobe accepted after the start pulse. `resStamp` is the number of the window's first sample plus the window length divided by two, rounded down.
- R6: When the result count reaches `cfgMaxOut` (≥ 1), the trace ends. `traceDone` pulses in the cycle after the last `resValid`, and no further result follows until the next start.
- R7: When `cfgDuration` (≥ 1) raw samples have been accepted, the trace ends. A window that is still open is discarded. If the final sample did not close a window, `traceDone` pulses two cycles after that sample's strobe cycle.
- R8: `traceDone` is high for exactly one cycle and is never high in the same cycle as `resValid`.
- R9: A start pulse in any state discards the partial window and any division in progress, and restarts numbering at 0. A strobe in the same cycle as the start is ignored.
- R10: The configuration is captured at the start pulse. Changes to the configuration inputs during a trace have no effect on that trace.
- R11: `resValid` rises exactly DATA_W+WIN_W cycles after the cycle whose strobe closed the window. Strobes must be at least DATA_W+WIN_W+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Arms a new trace and captures the configuration |
| cfgLog | input | 1 | 1 selects logarithmic spacing, 0 selects uniform |
| cfgPerDecade | input | PD_W | Results per window size in logarithmic mode |
| cfgUniWin | input | WIN_W | Window length in uniform mode |
| cfgMaxOut | input | COUNT_W | Result budget of a trace |
| cfgDuration | input | TIME_W | Raw-sample budget of a trace |
| sampleStrobe | input | 1 | Raw sample present this cycle |
| sampleData | input | DATA_W | Raw sample, two's complement |
| resValid | output | 1 | One-cycle strobe for a finished average |
| resData | output | DATA_W | Averaged value |
| resStamp | output | TIME_W | Window midpoint in raw-sample periods |
| traceDone | output | 1 | One-cycle end-of-trace pulse |

## Verification
The bench builds the block with WIN_W=8, MAX_EXP=2, PD_W=8, COUNT_W=12 and TIME_W=20. With these values the window ceiling of 100 is reached after a few hundred raw samples, so the growth, the cap and the plateau after the cap all occur within one short trace. The divider latency shrinks to 24 cycles, which allows dense strobes, and full-scale windows then test the sign and truncation handling of the divider at its largest magnitude. Small widths on the counters keep the budget and duration limits, and a restart while a division is in flight, cheap to reach.

// File: rtl/lds_pkg.sv
package lds_pkg;

  typedef struct packed {
    logic clear;
    logic accum;
    logic close;
  } ldsStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } ldsState_t;

  function automatic longint pow10(input int e);
    longint r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * 10;
    return r;
  endfunction

endpackage

// File: rtl/lds_ctrl.sv
module lds_ctrl
  import lds_pkg::*;
#(
  parameter int WIN_W   = 20,
  parameter int PD_W    = 14,
  parameter int COUNT_W = 20,
  parameter int TIME_W  = 37,
  parameter int MAX_EXP = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               cfgLog,
  input  logic [PD_W-1:0]    cfgPerDecade,
  input  logic [WIN_W-1:0]   cfgUniWin,
  input  logic [COUNT_W-1:0] cfgMaxOut,
  input  logic [TIME_W-1:0]  cfgDuration,
  input  logic               sampleStrobe,
  input  logic               divBusy,
  output ldsStrobe_t         strb,
  output logic [TIME_W-1:0]  winStart,
  output logic [WIN_W-1:0]   width,
  output logic               traceDone
);

  localparam logic [WIN_W-1:0] WIN_CAP = WIN_W'(pow10(MAX_EXP));

  ldsState_t          state;
  logic               modeLog;
  logic [PD_W-1:0]    perDec;
  logic [COUNT_W-1:0] maxOut;
  logic [TIME_W-1:0]  durLim;
  logic [WIN_W-1:0]   inWin;
  logic [PD_W-1:0]    grp;
  logic [COUNT_W-1:0] outCnt;
  logic [TIME_W-1:0]  rawIdx;

  logic               accepted;
  logic               closeNow;
  logic               lastOut;
  logic               lastRaw;
  logic               groupEnd;
  logic [WIN_W-1:0]   widthTimes10;
  logic [WIN_W-1:0]   nextWidth;

  always_comb begin
    accepted     = sampleStrobe && !startPulse && (state == ST_RUN);
    closeNow     = accepted && (inWin == width - WIN_W'(1));
    lastOut      = (outCnt + COUNT_W'(1)) == maxOut;
    lastRaw      = (rawIdx + TIME_W'(1)) == durLim;
    groupEnd     = (grp == perDec - PD_W'(1));
    widthTimes10 = (width << 3) + (width << 1);
    nextWidth    = (width >= WIN_CAP) ? WIN_CAP : widthTimes10;
    strb         = '0;
    strb.clear   = startPulse;
    strb.close   = closeNow;
    strb.accum   = accepted && !closeNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      modeLog   <= 1'b0;
      perDec    <= '0;
      maxOut    <= '0;
      durLim    <= '0;
      width     <= WIN_W'(1);
      inWin     <= '0;
      grp       <= '0;
      outCnt    <= '0;
      rawIdx    <= '0;
      winStart  <= '0;
      traceDone <= 1'b0;
    end else if (startPulse) begin
      state     <= ST_RUN;
      modeLog   <= cfgLog;
      perDec    <= cfgPerDecade;
      maxOut    <= cfgMaxOut;
      durLim    <= cfgDuration;
      width     <= cfgLog ? WIN_W'(1) : cfgUniWin;
      inWin     <= '0;
      grp       <= '0;
      outCnt    <= '0;
      rawIdx    <= '0;
      winStart  <= '0;
      traceDone <= 1'b0;
    end else begin
      traceDone <= 1'b0;
      case (state)
        ST_RUN: begin
          if (accepted) begin
            rawIdx <= rawIdx + TIME_W'(1);
            if (closeNow) begin
              inWin    <= '0;
              winStart <= rawIdx + TIME_W'(1);
              outCnt   <= outCnt + COUNT_W'(1);
              if (modeLog) begin
                if (groupEnd) begin
                  grp   <= '0;
                  width <= nextWidth;
                end else begin
                  grp <= grp + PD_W'(1);
                end
              end
            end else begin
              inWin <= inWin + WIN_W'(1);
            end
            if ((closeNow && lastOut) || lastRaw) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (!divBusy) begin
            traceDone <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lds_datapath.sv
module lds_datapath
  import lds_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WIN_W  = 20,
  parameter int TIME_W = 37
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldsStrobe_t        strb,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [TIME_W-1:0] winStart,
  input  logic [WIN_W-1:0]  width,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [TIME_W-1:0] resStamp,
  output logic              divBusy
);

  localparam int SUM_W  = DATA_W + WIN_W;
  localparam int ITER_W = $clog2(SUM_W);
  localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(SUM_W - 1);

  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] sampleExt;
  logic signed [SUM_W-1:0] total;
  logic [SUM_W-1:0]        totalU;
  logic [SUM_W-1:0]        mag;
  logic [TIME_W-1:0]       stampNext;

  logic [ITER_W-1:0]       iter;
  logic                    negReg;
  logic [SUM_W-1:0]        quo;
  logic [WIN_W:0]          rem;
  logic [WIN_W-1:0]        divisor;
  logic [TIME_W-1:0]       stampReg;

  logic [WIN_W:0]          shifted;
  logic                    fits;
  logic [WIN_W:0]          remNext;
  logic [SUM_W-1:0]        quoNext;
  logic [DATA_W-1:0]       qFinal;
  logic [DATA_W-1:0]       resNext;

  always_comb begin
    sampleExt = {{WIN_W{sampleData[DATA_W-1]}}, sampleData};
    total     = acc + sampleExt;
    totalU    = total;
    mag       = total[SUM_W-1] ? (~totalU + SUM_W'(1)) : totalU;
    stampNext = winStart + TIME_W'(width >> 1);
  end

  always_comb begin
    shifted = {rem[WIN_W-1:0], quo[SUM_W-1]};
    fits    = shifted >= {1'b0, divisor};
    remNext = fits ? (shifted - {1'b0, divisor}) : shifted;
    quoNext = {quo[SUM_W-2:0], fits};
    qFinal  = quoNext[DATA_W-1:0];
    resNext = negReg ? (~qFinal + DATA_W'(1)) : qFinal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      divBusy  <= 1'b0;
      iter     <= '0;
      negReg   <= 1'b0;
      quo      <= '0;
      rem      <= '0;
      divisor  <= '0;
      stampReg <= '0;
      resValid <= 1'b0;
      resData  <= '0;
      resStamp <= '0;
    end else begin
      resValid <= 1'b0;
      if (strb.clear) begin
        acc     <= '0;
        divBusy <= 1'b0;
      end else begin
        if (divBusy) begin
          rem <= remNext;
          quo <= quoNext;
          if (iter == LAST_ITER) begin
            divBusy  <= 1'b0;
            resValid <= 1'b1;
            resData  <= resNext;
            resStamp <= stampReg;
          end else begin
            iter <= iter + ITER_W'(1);
          end
        end
        if (strb.close) begin
          acc      <= '0;
          divBusy  <= 1'b1;
          iter     <= '0;
          quo      <= mag;
          rem      <= '0;
          divisor  <= width;
          negReg   <= total[SUM_W-1];
          stampReg <= stampNext;
        end else if (strb.accum) begin
          acc <= total;
        end
      end
    end
  end

endmodule

// File: rtl/lds_top.sv
module lds_top
  import lds_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int WIN_W   = 20,
  parameter int PD_W    = 14,
  parameter int COUNT_W = 20,
  parameter int TIME_W  = 37,
  parameter int MAX_EXP = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               cfgLog,
  input  logic [PD_W-1:0]    cfgPerDecade,
  input  logic [WIN_W-1:0]   cfgUniWin,
  input  logic [COUNT_W-1:0] cfgMaxOut,
  input  logic [TIME_W-1:0]  cfgDuration,
  input  logic               sampleStrobe,
  input  logic [DATA_W-1:0]  sampleData,
  output logic               resValid,
  output logic [DATA_W-1:0]  resData,
  output logic [TIME_W-1:0]  resStamp,
  output logic               traceDone
);

  ldsStrobe_t        strb;
  logic [TIME_W-1:0] winStart;
  logic [WIN_W-1:0]  width;
  logic              divBusy;

  lds_ctrl #(
    .WIN_W(WIN_W), .PD_W(PD_W), .COUNT_W(COUNT_W),
    .TIME_W(TIME_W), .MAX_EXP(MAX_EXP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cfgLog(cfgLog),
    .cfgPerDecade(cfgPerDecade), .cfgUniWin(cfgUniWin), .cfgMaxOut(cfgMaxOut),
    .cfgDuration(cfgDuration), .sampleStrobe(sampleStrobe), .divBusy(divBusy),
    .strb(strb), .winStart(winStart), .width(width), .traceDone(traceDone)
  );

  lds_datapath #(
    .DATA_W(DATA_W), .WIN_W(WIN_W), .TIME_W(TIME_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleData(sampleData),
    .winStart(winStart), .width(width), .resValid(resValid),
    .resData(resData), .resStamp(resStamp), .divBusy(divBusy)
  );

endmodule

// File: rtl/lds_checker.sv
module lds_checker #(
  parameter int COUNT_W = 20,
  parameter int TIME_W  = 37
) (
  input logic               clk,
  input logic               rstN,
  input logic               startPulse,
  input logic [COUNT_W-1:0] cfgMaxOut,
  input logic               resValid,
  input logic [TIME_W-1:0]  resStamp,
  input logic               traceDone,
  input logic               divBusy
);

  logic               armed;
  logic               seenAny;
  logic [COUNT_W-1:0] outSeen;
  logic [COUNT_W-1:0] budget;
  logic [TIME_W-1:0]  lastStamp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      seenAny   <= 1'b0;
      outSeen   <= '0;
      budget    <= '0;
      lastStamp <= '0;
    end else if (startPulse) begin
      armed   <= 1'b1;
      seenAny <= 1'b0;
      outSeen <= '0;
      budget  <= cfgMaxOut;
    end else begin
      if (traceDone) armed <= 1'b0;
      if (resValid) begin
        seenAny   <= 1'b1;
        outSeen   <= outSeen + COUNT_W'(1);
        lastStamp <= resStamp;
      end
    end
  end

  // R8: the end pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    traceDone |=> !traceDone);

  // R8: end pulse and result strobe never coincide
  a_r8_done_not_with_result: assert property (@(posedge clk) disable iff (!rstN)
    traceDone |-> !resValid);

  // R1 / R6: no result outside an armed trace
  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !startPulse) |-> !resValid);

  // R6: the result count stays within the budget
  a_r6_within_budget: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && armed && !startPulse) |-> (outSeen < budget));

  // R5: midpoint tags rise strictly within a trace
  a_r5_stamp_rising: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && seenAny && !startPulse) |-> (resStamp > lastStamp));

  // R11: a result is delivered as the divider goes idle
  a_r11_result_ends_division: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ($past(divBusy) && !divBusy));

endmodule

bind lds_top lds_checker #(.COUNT_W(COUNT_W), .TIME_W(TIME_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .cfgMaxOut(cfgMaxOut),
  .resValid(resValid), .resStamp(resStamp), .traceDone(traceDone),
  .divBusy(divBusy)
);

// File: tb/lds_top_bench.sv
`timescale 1ns/1ps
module lds_top_bench;

  localparam int DATA_W  = 16;
  localparam int WIN_W   = 8;
  localparam int PD_W    = 8;
  localparam int COUNT_W = 12;
  localparam int TIME_W  = 20;
  localparam int MAX_EXP = 2;
  localparam int SUM_W   = DATA_W + WIN_W;
  localparam int CAP     = 100;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               startPulse = 1'b0;
  logic               cfgLog = 1'b0;
  logic [PD_W-1:0]    cfgPerDecade = '0;
  logic [WIN_W-1:0]   cfgUniWin = '0;
  logic [COUNT_W-1:0] cfgMaxOut = '0;
  logic [TIME_W-1:0]  cfgDuration = '0;
  logic               sampleStrobe = 1'b0;
  logic [DATA_W-1:0]  sampleData = '0;
  logic               resValid;
  logic [DATA_W-1:0]  resData;
  logic [TIME_W-1:0]  resStamp;
  logic               traceDone;

  lds_top #(
    .DATA_W(DATA_W), .WIN_W(WIN_W), .PD_W(PD_W), .COUNT_W(COUNT_W),
    .TIME_W(TIME_W), .MAX_EXP(MAX_EXP)
  ) u_lds_top (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cfgLog(cfgLog),
    .cfgPerDecade(cfgPerDecade), .cfgUniWin(cfgUniWin), .cfgMaxOut(cfgMaxOut),
    .cfgDuration(cfgDuration), .sampleStrobe(sampleStrobe), .sampleData(sampleData),
    .resValid(resValid), .resData(resData), .resStamp(resStamp), .traceDone(traceDone)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit finished = 0;

  // reference model state
  bit     mRun = 0;
  bit     mLog;
  int     mPd, mMaxOut, mDur;
  longint mAcc;
  int     mWidth, mInWin, mGrp, mOut, mRaw, mStart;
  longint expData[$];
  longint expStamp[$];
  longint expCyc[$];
  bit     doneExp = 0;
  bit     doneSeen = 0;
  int     expDoneCyc;
  string  doneTag = "R6";
  string  tagData = "R2";
  int     dmode = 0;
  int     unexpected = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] nextData();
    case (dmode)
      1: return 16'h8000;
      2: return 16'h7fff;
      3: return DATA_W'($urandom_range(16) - 8);
      default: return DATA_W'($urandom);
    endcase
  endfunction

  task automatic modelSample(input logic [DATA_W-1:0] v, input int k0);
    bit closed;
    if (!mRun) return;
    closed = 0;
    mAcc += longint'($signed(v));
    if (mInWin == mWidth - 1) begin
      closed = 1;
      expData.push_back(mAcc / longint'(mWidth));
      expStamp.push_back(longint'(mStart + mWidth / 2));
      expCyc.push_back(longint'(k0 + 1 + SUM_W));
      mOut++;
      mStart = mRaw + 1;
      mAcc = 0;
      mInWin = 0;
      if (mLog) begin
        if (mGrp == mPd - 1) begin
          mGrp = 0;
          if (mWidth < CAP) mWidth = mWidth * 10;
        end else mGrp++;
      end
    end else mInWin++;
    mRaw++;
    if ((closed && mOut == mMaxOut) || mRaw == mDur) begin
      mRun = 0;
      doneExp = 1;
      doneTag = (closed && mOut == mMaxOut) ? "R6" : "R7";
      expDoneCyc = closed ? k0 + 2 + SUM_W : k0 + 2;
    end
  endtask

  task automatic sendSample(input logic [DATA_W-1:0] v, input int gap);
    repeat (gap) @(negedge clk);
    sampleStrobe = 1'b1;
    sampleData = v;
    modelSample(v, cyc);
    @(negedge clk);
    sampleStrobe = 1'b0;
  endtask

  task automatic startRun(input bit lg, input int pd, input int uw, input int mo,
                          input int dur, input bit withStrobe);
    @(negedge clk);
    cfgLog = lg;
    cfgPerDecade = PD_W'(pd);
    cfgUniWin = WIN_W'(uw);
    cfgMaxOut = COUNT_W'(mo);
    cfgDuration = TIME_W'(dur);
    startPulse = 1'b1;
    sampleStrobe = withStrobe;
    sampleData = 16'h1234;
    mRun = 1; mLog = lg; mPd = pd; mMaxOut = mo; mDur = dur;
    mAcc = 0; mWidth = lg ? 1 : uw; mInWin = 0; mGrp = 0; mOut = 0;
    mRaw = 0; mStart = 0;
    expData.delete(); expStamp.delete(); expCyc.delete();
    doneExp = 0; doneSeen = 0;
    @(negedge clk);
    startPulse = 1'b0;
    sampleStrobe = 1'b0;
  endtask

  task automatic runToEnd();
    while (mRun) sendSample(nextData(), 26 + int'($urandom_range(7)));
    for (int i = 0; i < 3000 && !doneSeen; i++) @(negedge clk);
    check(doneSeen, doneTag, longint'(doneSeen), 1);
    check(expData.size() == 0, doneTag, longint'(expData.size()), 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expData.size() == 0) begin
        unexpected++;
        check(0, "R1/R6 unexpected result", 1, 0);
      end else begin
        check(longint'($signed(resData)) == expData[0], tagData,
              longint'($signed(resData)), expData[0]);
        check(longint'(resStamp) == expStamp[0], "R5", longint'(resStamp), expStamp[0]);
        check(longint'(cyc) == expCyc[0], "R11", longint'(cyc), expCyc[0]);
        void'(expData.pop_front());
        void'(expStamp.pop_front());
        void'(expCyc.pop_front());
      end
    end
    if (rstN && traceDone) begin
      check(!resValid, "R8", longint'(resValid), 0);
      check(doneExp, "R8", longint'(doneExp), 1);
      if (doneExp) check(cyc == expDoneCyc, doneTag, longint'(cyc), longint'(expDoneCyc));
      doneExp = 0;
      doneSeen = 1;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check(resValid == 1'b0, "R1", longint'(resValid), 0);
    check(traceDone == 1'b0, "R1", longint'(traceDone), 0);
    rstN = 1'b1;

    // R1: strobes before any start are ignored
    for (int i = 0; i < 3; i++) sendSample(nextData(), 30);
    repeat (40) @(negedge clk);
    check(unexpected == 0, "R1", longint'(unexpected), 0);
    check(traceDone == 1'b0, "R1", longint'(traceDone), 0);

    // R2 / R6: log spacing, two per size, ceiling reached, ended by budget
    tagData = "R2"; dmode = 0;
    startRun(1, 2, 0, 7, 100000, 0);
    runToEnd();

    // R4: full-scale negative and positive windows
    tagData = "R4"; dmode = 1;
    startRun(1, 1, 0, 4, 100000, 0);
    runToEnd();
    dmode = 2;
    startRun(1, 1, 0, 3, 100000, 0);
    runToEnd();

    // R3 / R7: uniform width 5, duration leaves an open window
    tagData = "R3"; dmode = 3;
    startRun(0, 0, 5, 50, 23, 0);
    runToEnd();

    // R3 / R7: uniform width 1, last sample closes a window
    dmode = 0;
    startRun(0, 0, 1, 50, 6, 0);
    runToEnd();

    // R9: restart right after a closing strobe, with a strobe on the start
    tagData = "R9"; dmode = 0;
    startRun(1, 2, 0, 20, 100000, 0);
    for (int i = 0; i < 12; i++) sendSample(nextData(), 26);
    startRun(0, 0, 4, 3, 1000, 1);
    runToEnd();

    // R10: configuration changes mid-trace are ignored
    tagData = "R10"; dmode = 3;
    startRun(0, 0, 3, 3, 1000, 0);
    sendSample(nextData(), 26);
    cfgLog = 1'b1; cfgUniWin = 8'd7; cfgMaxOut = 12'd1; cfgDuration = 20'd2;
    runToEnd();

    repeat (20) @(negedge clk);
    check(unexpected == 0, "R6", longint'(unexpected), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule